// File: doc/BRIEF.md
# Rate-1/3 Parallel Concatenated Convolutional Encoder

The block turns a block of K information bits into a rate-1/3 parallel concatenated code. Bits arrive one per accepted transfer on a valid/ready stream, and a start-of-block flag marks the first bit of each block. The bits are kept in an internal block store. Once all K are held, the block reads them back once, one position per cycle. The bit at position i leaves unchanged as the systematic output. It also drives the first recursive systematic convolutional encoder. In the same cycle the bit at position pi(i) = (F1*i + F2*i*i) mod K is read and drives a second, identical encoder. pi(i) is produced one step at a time by an address generator made of modular adders, with no multiplier.

Both constituent encoders have four states and a rate of 1/2. Their feedback polynomial is 1+D+D^2 and their feedforward polynomial is 1+D^2. Both are cleared at every start-of-block, and no tail bits are added. As the last position leaves, the whole codeword is presented as one vector: first the systematic bits, then the parity-1 bits, then the parity-2 bits.

The controller has four states:
- S_IDLE: waits for a start-of-block transfer.
- S_LOAD: collects the rest of the block.
- S_ENCODE: emits one coded position per cycle.
- S_DONE: presents the codeword for one cycle.

Transitions:
- S_IDLE -> S_LOAD on an accepted start-of-block bit.
- S_LOAD -> S_LOAD on a new start-of-block, which restarts the block.
- S_LOAD -> S_ENCODE on the K-th accepted bit.
- S_ENCODE -> S_DONE on the last position.
- S_DONE -> S_IDLE unconditionally.

Top module: `pcc_encoder`

## Requirements
- R1: After reset, out_valid and cw_valid are 0 and in_ready is 1.
- R2: A transfer happens on a clock edge where in_valid and in_ready are both 1. In the idle state, a transfer with in_sob = 0 is dropped and never appears in any output.
- R3: A transfer with in_sob = 1 while a block is being loaded discards the bits already loaded. That bit becomes position 0 of a new block.
- R4: From the edge that accepts the K-th bit until the block's outputs are finished, in_ready is 0. In particular, in_ready is 0 whenever out_valid is 1.
- R5: The first output of a block appears on the edge after the edge that accepts its K-th bit. out_valid is then 1 for exactly K consecutive cycles, and out_sys in the i-th of those cycles equals input bit i of the block.
- R6: out_intl in the i-th output cycle equals input bit pi(i), where pi(i) = (F1*i + F2*i*i) mod K.
- R7: out_par1 is the parity of a recursive encoder fed the bits in natural order, starting from state s1 = s2 = 0. For each input bit u: fb = u^s1^s2, parity = fb^s2, then s1 becomes fb and s2 becomes the old s1.
- R8: out_par2 is the parity of the same recursive encoder, also starting from zero, fed the interleaved bits out_intl in output order.
- R9: cw_valid is 1 for exactly one cycle, the cycle of the last output of the block. In that cycle, cw_data bit i is systematic bit i, bit K+i is parity-1 bit i, and bit 2K+i is parity-2 bit i, for i = 0..K-1.
- R10: Encoder state never carries from one block to the next: the same block data always produces the same codeword.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input bit is valid |
| in_ready | output | 1 | Block can accept an input bit |
| in_bit | input | 1 | Information bit |
| in_sob | input | 1 | Marks the first bit of a block |
| out_valid | output | 1 | One coded position is presented |
| out_sys | output | 1 | Systematic bit |
| out_par1 | output | 1 | Parity from the natural-order encoder |
| out_par2 | output | 1 | Parity from the interleaved-order encoder |
| out_intl | output | 1 | Interleaved information bit |
| cw_valid | output | 1 | Codeword vector is valid |
| cw_data | output | 3*K | Codeword: systematic, parity-1, parity-2 |

## Verification
The driver notes the edge that accepts a block's last bit. The first out_valid must be seen at the falling edge right after the next rising edge: one register stage after the last accept. Each output position is then due one cycle after the previous one, so out_valid must stay high for exactly K sampled cycles, with in_ready low throughout. The codeword vector is due in the same cycle as the last position. All outputs are sampled on falling edges, half a period after the register that drives them has settled. Items are compared in order against a queue that the driver fills from its own model of the permutation and of the recursive encoders.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_LOAD   = 2'd1,
        S_ENCODE = 2'd2,
        S_DONE   = 2'd3
    } pcc_state_t;
endpackage

// File: rtl/block_buffer.sv
module block_buffer #(
    parameter int K  = 40,
    parameter int AW = $clog2(K)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_bit,
    input  logic [AW-1:0] rd_addr_a,
    input  logic [AW-1:0] rd_addr_b,
    output logic          rd_bit_a,
    output logic          rd_bit_b
);
    logic [K-1:0] mem_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_bit;
        end
    end

    // Two independent read ports: natural order and interleaved order
    always_comb begin
        rd_bit_a = mem_q[rd_addr_a];
        rd_bit_b = mem_q[rd_addr_b];
    end
endmodule

// File: rtl/qpp_addr_gen.sv
module qpp_addr_gen #(
    parameter int K  = 40,
    parameter int F1 = 3,
    parameter int F2 = 10,
    parameter int AW = $clog2(K)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init,
    input  logic          step,
    output logic [AW-1:0] addr
);
    localparam logic [AW:0]   KW = (AW+1)'(K);
    localparam logic [AW-1:0] G0 = AW'((F1 + F2) % K);
    localparam logic [AW-1:0] D2 = AW'((2 * F2) % K);

    logic [AW-1:0] addr_q;
    logic [AW-1:0] inc_q;

    function automatic logic [AW-1:0] mod_add(input logic [AW-1:0] a, input logic [AW-1:0] b);
        logic [AW:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= KW) begin
            s = s - KW;
        end
        return s[AW-1:0];
    endfunction

    // pi(i+1) = pi(i) + g(i);  g(i+1) = g(i) + 2*F2  (all mod K)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            inc_q  <= G0;
        end else if (init) begin
            addr_q <= '0;
            inc_q  <= G0;
        end else if (step) begin
            addr_q <= mod_add(addr_q, inc_q);
            inc_q  <= mod_add(inc_q, D2);
        end
    end

    assign addr = addr_q;

    assert_addr_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, addr_q} < KW);
endmodule

// File: rtl/rsc_encoder.sv
module rsc_encoder (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    input  logic u,
    output logic parity
);
    logic s1_q;
    logic s2_q;
    logic fb;

    // feedback 1+D+D^2, feedforward 1+D^2
    always_comb begin
        fb     = u ^ s1_q ^ s2_q;
        parity = fb ^ s2_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else if (clear) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else if (step) begin
            s1_q <= fb;
            s2_q <= s1_q;
        end
    end

    assert_state_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear) |=> (s2_q == $past(s1_q)));
endmodule

// File: rtl/pcc_encoder.sv
module pcc_encoder #(
    parameter int K  = 40,
    parameter int F1 = 3,
    parameter int F2 = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic           in_bit,
    input  logic           in_sob,
    output logic           out_valid,
    output logic           out_sys,
    output logic           out_par1,
    output logic           out_par2,
    output logic           out_intl,
    output logic           cw_valid,
    output logic [3*K-1:0] cw_data
);
    import pcc_pkg::*;

    localparam int            AW   = $clog2(K);
    localparam logic [AW-1:0] LAST = AW'(K - 1);

    pcc_state_t    state_q, state_d;
    logic [AW-1:0] idx_q;
    logic          accept;
    logic          start_blk;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic          bit_nat, bit_int;
    logic [AW-1:0] pi_addr;
    logic          par1, par2;
    logic          encoding;
    logic [K-1:0]  sys_q, p1_q, p2_q;

    assign in_ready  = (state_q == S_IDLE) || (state_q == S_LOAD);
    assign accept    = in_valid && in_ready;
    assign start_blk = accept && in_sob;
    assign wr_en     = start_blk || (accept && state_q == S_LOAD);
    assign wr_addr   = in_sob ? '0 : idx_q;
    assign encoding  = (state_q == S_ENCODE);

    block_buffer #(.K(K), .AW(AW)) buf_i (
        .clk       (clk),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_bit    (in_bit),
        .rd_addr_a (idx_q),
        .rd_addr_b (pi_addr),
        .rd_bit_a  (bit_nat),
        .rd_bit_b  (bit_int)
    );

    qpp_addr_gen #(.K(K), .F1(F1), .F2(F2), .AW(AW)) qpp_i (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (start_blk),
        .step  (encoding),
        .addr  (pi_addr)
    );

    rsc_encoder enc1_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start_blk),
        .step   (encoding),
        .u      (bit_nat),
        .parity (par1)
    );

    rsc_encoder enc2_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start_blk),
        .step   (encoding),
        .u      (bit_int),
        .parity (par2)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_blk) state_d = S_LOAD;
            end
            S_LOAD: begin
                if (accept && !in_sob && idx_q == LAST) state_d = S_ENCODE;
            end
            S_ENCODE: begin
                if (idx_q == LAST) state_d = S_DONE;
            end
            S_DONE: begin
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            out_valid <= 1'b0;
            out_sys   <= 1'b0;
            out_par1  <= 1'b0;
            out_par2  <= 1'b0;
            out_intl  <= 1'b0;
            sys_q     <= '0;
            p1_q      <= '0;
            p2_q      <= '0;
        end else begin
            out_valid <= encoding;
            unique case (state_q)
                S_IDLE, S_LOAD: begin
                    if (start_blk) begin
                        idx_q <= AW'(1);
                    end else if (accept && state_q == S_LOAD) begin
                        idx_q <= (idx_q == LAST) ? '0 : idx_q + AW'(1);
                    end
                end
                S_ENCODE: begin
                    out_sys      <= bit_nat;
                    out_intl     <= bit_int;
                    out_par1     <= par1;
                    out_par2     <= par2;
                    sys_q[idx_q] <= bit_nat;
                    p1_q[idx_q]  <= par1;
                    p2_q[idx_q]  <= par2;
                    idx_q        <= (idx_q == LAST) ? '0 : idx_q + AW'(1);
                end
                S_DONE: begin
                    idx_q <= '0;
                end
                default: idx_q <= '0;
            endcase
        end
    end

    assign cw_valid = (state_q == S_DONE);
    assign cw_data  = {p2_q, p1_q, sys_q};

    assert_busy_while_output_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    assert_cw_with_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cw_valid |-> out_valid);

    assert_cw_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cw_valid |=> !cw_valid);

    assert_output_follows_encode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> ($past(state_q) == S_ENCODE));
endmodule

// File: tb/pcc_encoder_tb_top.sv
`timescale 1ns/1ps
module pcc_encoder_tb_top;
    localparam int K  = 40;
    localparam int F1 = 3;
    localparam int F2 = 10;

    typedef struct packed {
        logic s;
        logic i;
        logic p1;
        logic p2;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic in_sob = 1'b0;
    logic in_ready;
    logic out_valid, out_sys, out_par1, out_par2, out_intl, cw_valid;
    logic [3*K-1:0] cw_data;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int negcount = 0;
    int exp_first_neg = -1;
    int run_len  = 0;
    bit done     = 1'b0;

    item_t          exp_q[$];
    logic [3*K-1:0] cw_q[$];

    always #10 clk = ~clk;

    pcc_encoder #(.K(K), .F1(F1), .F2(F2)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit), .in_sob(in_sob),
        .out_valid(out_valid), .out_sys(out_sys), .out_par1(out_par1),
        .out_par2(out_par2), .out_intl(out_intl),
        .cw_valid(cw_valid), .cw_data(cw_data)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    function automatic int pi_of(input int i);
        longint v;
        v = (longint'(F1) * i + longint'(F2) * i * i) % K;
        return int'(v);
    endfunction

    // expected model: permutation and two recursive encoders from zero state
    task automatic push_block(input logic [K-1:0] d);
        logic a1, a2, b1, b2, u, v, fa, fb, p1, p2;
        logic [3*K-1:0] cw;
        item_t it;
        a1 = 0; a2 = 0; b1 = 0; b2 = 0; cw = '0;
        for (int i = 0; i < K; i++) begin
            u  = d[i];
            v  = d[pi_of(i)];
            fa = u ^ a1 ^ a2; p1 = fa ^ a2; a2 = a1; a1 = fa;
            fb = v ^ b1 ^ b2; p2 = fb ^ b2; b2 = b1; b1 = fb;
            it.s = u; it.i = v; it.p1 = p1; it.p2 = p2;
            exp_q.push_back(it);
            cw[i] = u; cw[K+i] = p1; cw[2*K+i] = p2;
        end
        cw_q.push_back(cw);
    endtask

    task automatic send_bit(input logic b, input logic sob);
        bit ok;
        @(negedge clk);
        in_valid = 1'b1; in_bit = b; in_sob = sob;
        forever begin
            ok = in_ready;
            @(posedge clk);
            if (ok) break;
            @(negedge clk);
        end
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        in_valid = 1'b0; in_sob = 1'b0;
        @(posedge clk);
    endtask

    task automatic send_block(input logic [K-1:0] d, input bit gaps);
        push_block(d);
        for (int i = 0; i < K; i++) begin
            send_bit(d[i], i == 0);
            if (i == K - 1) exp_first_neg = negcount + 2;
            if (gaps && (i % 7 == 3)) idle_cycle();
        end
        @(negedge clk);
        in_valid = 1'b0; in_sob = 1'b0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        item_t e;
        logic [3*K-1:0] ce;
        negcount++;
        if (rst_n) begin
            if (out_valid) begin
                if (run_len == 0)
                    check(negcount == exp_first_neg, "R5 first-output latency", 128'(negcount), 128'(exp_first_neg));
                run_len++;
                check(!in_ready, "R4 in_ready low during output", 128'(in_ready), 128'(0));
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected output (R2 R3)", 128'(1), 128'(0));
                end else begin
                    e = exp_q.pop_front();
                    check(out_sys  == e.s,  "R5 systematic (R2 R3)", 128'(out_sys),  128'(e.s));
                    check(out_intl == e.i,  "R6 interleaved bit",    128'(out_intl), 128'(e.i));
                    check(out_par1 == e.p1, "R7 parity1",            128'(out_par1), 128'(e.p1));
                    check(out_par2 == e.p2, "R8 parity2",            128'(out_par2), 128'(e.p2));
                end
            end else if (run_len != 0) begin
                check(run_len == K, "R5 output run length", 128'(run_len), 128'(K));
                run_len = 0;
            end
            if (cw_valid) begin
                check(run_len == K, "R9 cw_valid with last position", 128'(run_len), 128'(K));
                if (cw_q.size() == 0) begin
                    check(1'b0, "R9 unexpected codeword", 128'(1), 128'(0));
                end else begin
                    ce = cw_q.pop_front();
                    check(cw_data == ce, "R9 R10 codeword", 128'(cw_data), 128'(ce));
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            check(1'b0, "watchdog", 128'(cyc), 128'(100000));
            summary();
        end
    end

    initial begin
        logic [K-1:0] d_imp, d_lfsr, d_part, d_ones;
        logic [K-1:0] lf;
        d_imp = '0; d_imp[0] = 1'b1;
        lf = K'(40'h9A3C5E7F1B);
        for (int i = 0; i < K; i++) begin
            d_lfsr[i] = lf[0];
            lf = {lf[0] ^ lf[3], lf[K-1:1]};
        end
        d_part = ~d_lfsr;
        d_ones = '1;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1 out_valid at reset", 128'(out_valid), 128'(0));
        check(cw_valid  == 1'b0, "R1 cw_valid at reset",  128'(cw_valid),  128'(0));
        check(in_ready  == 1'b1, "R1 in_ready at reset",  128'(in_ready),  128'(1));
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // impulse block, with input gaps
        send_block(d_imp, 1'b1);

        // R2: bits without start-of-block are dropped in idle (held while busy)
        for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b0);
        idle_cycle();
        send_block(d_lfsr, 1'b0);

        // R3: partial block, then restart with a new start-of-block
        for (int i = 0; i < 12; i++) send_bit(1'b1, i == 0);
        send_block(d_part, 1'b1);

        send_block(d_ones, 1'b0);
        // R10: repeat of the first block must give the same codeword
        send_block(d_imp, 1'b0);

        repeat (2 * K + 10) @(posedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, "R5 all positions emitted", 128'(exp_q.size()), 128'(0));
        check(cw_q.size() == 0, "R9 all codewords emitted", 128'(cw_q.size()), 128'(0));
        done = 1'b1;
        summary();
    end
endmodule